// File: doc/BRIEF.md
# Machine-Mode Interrupt Priority Controller

This block gathers a set of hardware interrupt request lines and hands the most urgent one to a single processor core that runs only in machine mode. Each line is edge-captured: a rising edge turns into a one-cycle pulse that sets the source's pending bit. Software gives every source a priority and an enable bit, and can turn on a suppression mode that hides sources whose priority lies below a programmed floor. A combinational resolver picks the winning source, drives the core's external interrupt input and exposes the winning ID at a claim register.

Software reads the claim register to take an interrupt. The read returns the winning ID, clears that source's pending bit and marks it in service. Edges that arrive on a source while it is in service are dropped. Writing the same ID back to the claim register ends service, and the next rising edge pends the source again. All registers are 32 bits wide and sit in the 32-bit address window 0xE000_0000 to 0xE000_FFFF. The controller uses a plain synchronous register bus: address, write data, write strobe, read strobe and a combinational read data path.

Top module: `irq_hub`

## Requirements
- R1: After reset, the pending, enable, priority and suppression registers hold zero, `ext_irq` is low and a claim read returns 0.
- R2: Input bit k belongs to source ID k+1. A rising edge on that bit, sampled at a clock edge, sets pending bit ID at that edge. A line that stays high sets it only once. The pending word is read at 0xE000_1000, with bit position equal to the ID and bit 0 always 0.
- R3: The enable word at 0xE000_2000 has one bit per ID, at the bit position equal to the ID. A pending source whose enable bit is 0 never raises `ext_irq` and is never claimed. Setting the bit later makes the source eligible.
- R4: The priority of source ID is the low PRIO_W bits of the word at 0xE000_0000 + 4*ID, and reads back zero-extended. A source with priority 0 is never selected.
- R5: Among the eligible sources, the highest priority wins. On equal priority, the lowest ID wins.
- R6: The control word at 0xE000_2004 holds the suppression enable in bit 31 and the floor level in bits PRIO_W-1:0. While bit 31 is 1, sources whose priority is below the floor are not eligible. While bit 31 is 0, the floor has no effect.
- R7: A read at 0xE000_2008 returns the winning ID, or 0 if no source is eligible. At the clock edge of a read that returns a non-zero ID, the pending bit of that source clears.
- R8: A claimed source stays in service until its ID is written to 0xE000_2008. Rising edges that arrive during service set nothing. After completion, a new rising edge pends the source again.
- R9: `ext_irq` is high in exactly the cycles in which some source is eligible. It follows a register write at the clock edge of that write, with no added delay.
- R10: Accesses whose address lies outside 0xE000_0000..0xE000_FFFF, or that hit no register, read 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NSRC | Hardware request lines; bit k is source ID k+1 |
| bus_addr | input | 32 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, acts at the clock edge |
| bus_re | input | 1 | Read strobe; a claim read's side effect acts at the clock edge |
| bus_rdata | output | 32 | Combinational read data for the current address |
| ext_irq | output | 1 | External interrupt request to the core |

## Verification
The checker watches four properties on every cycle. A fully masked controller never raises `ext_irq`. A pending bit only appears after the matching line was high. No source is pending and in service at the same time. A claim-register read returns a non-zero ID exactly when `ext_irq` is high, and that ID is in service on the next cycle. Other behaviour needs the bench's directed scenarios: the order of the winners under priority ties, whether the suppression floor is inclusive, dropped edges during service, and address decode.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic [31:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [31:0]     bus_rdata,
  output logic            ext_irq
);
  localparam int IDW = $clog2(NSRC + 1);
  localparam logic [15:0] OFF_PEND  = 16'h1000;
  localparam logic [15:0] OFF_EN    = 16'h2000;
  localparam logic [15:0] OFF_CTRL  = 16'h2004;
  localparam logic [15:0] OFF_CLAIM = 16'h2008;

  logic [NSRC:1]      pend_q, en_q, svc_q, elig;
  logic [NSRC:1]      claim_m, done_m, pulse;
  logic [NSRC-1:0]    prev_q;
  logic [PRIO_W-1:0]  prio_q [1:NSRC];
  logic               sup_on_q;
  logic [PRIO_W-1:0]  floor_q;
  logic [IDW-1:0]     win_id;
  logic [PRIO_W-1:0]  win_p;

  wire        in_win   = bus_addr[31:16] == 16'hE000;
  wire [15:0] off      = bus_addr[15:0];
  wire        hit_pend  = in_win && off == OFF_PEND;
  wire        hit_en    = in_win && off == OFF_EN;
  wire        hit_ctrl  = in_win && off == OFF_CTRL;
  wire        hit_claim = in_win && off == OFF_CLAIM;
  wire        hit_prio  = in_win && off[15:12] == 4'h0 && off[1:0] == 2'b00;
  wire [9:0]  prio_idx  = off[11:2];
  wire        do_claim  = bus_re && hit_claim && win_id != '0;
  wire        do_done   = bus_we && hit_claim;

  assign pulse   = irq_src & ~prev_q;
  assign ext_irq = win_id != '0;

  always_comb begin
    for (int i = 1; i <= NSRC; i++) begin
      elig[i]    = pend_q[i] && en_q[i] && prio_q[i] != '0 &&
                   (!sup_on_q || prio_q[i] >= floor_q);
      claim_m[i] = do_claim && win_id == IDW'(i);
      done_m[i]  = do_done && bus_wdata == 32'(i);
    end
  end

  always_comb begin
    win_id = '0;
    win_p  = '0;
    for (int i = 1; i <= NSRC; i++)
      if (elig[i] && prio_q[i] > win_p) begin
        win_p  = prio_q[i];
        win_id = IDW'(i);
      end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_pend)       bus_rdata = 32'({pend_q, 1'b0});
    else if (hit_en)    bus_rdata = 32'({en_q, 1'b0});
    else if (hit_ctrl)  bus_rdata = {sup_on_q, 31'(floor_q)};
    else if (hit_claim) bus_rdata = 32'(win_id);
    else if (hit_prio)
      for (int i = 1; i <= NSRC; i++)
        if (prio_idx == 10'(i)) bus_rdata = 32'(prio_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      pend_q   <= '0;
      svc_q    <= '0;
      en_q     <= '0;
      sup_on_q <= 1'b0;
      floor_q  <= '0;
      for (int i = 1; i <= NSRC; i++) prio_q[i] <= '0;
    end else begin
      prev_q <= irq_src;
      pend_q <= (pend_q | (pulse & ~svc_q)) & ~claim_m;
      svc_q  <= (svc_q & ~done_m) | claim_m;
      if (bus_we && hit_en) en_q <= bus_wdata[NSRC:1];
      if (bus_we && hit_ctrl) begin
        sup_on_q <= bus_wdata[31];
        floor_q  <= bus_wdata[PRIO_W-1:0];
      end
      if (bus_we && hit_prio)
        for (int i = 1; i <= NSRC; i++)
          if (prio_idx == 10'(i)) prio_q[i] <= bus_wdata[PRIO_W-1:0];
    end
  end
endmodule

module irq_hub_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_src,
  input logic [31:0]     bus_addr,
  input logic            bus_re,
  input logic [31:0]     bus_rdata,
  input logic            ext_irq,
  input logic [NSRC:1]   en_q,
  input logic [NSRC:1]   pend_q,
  input logic [NSRC:1]   svc_q
);
  localparam int IDW = $clog2(NSRC + 1);
  wire claim_rd = bus_re && bus_addr == 32'hE000_2008;

  // R3
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !ext_irq);
  // R2
  a_r2_pend_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(irq_src)) == '0));
  // R8
  a_r8_no_pend_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & svc_q) == '0));
  // R9
  a_r9_claim_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 32'hE000_2008) |-> ((bus_rdata != '0) == ext_irq));
  // R7
  a_r7_claim_takes_service: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && bus_rdata != '0) |=> svc_q[$past(bus_rdata[IDW-1:0])]);
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .ext_irq(ext_irq),
  .en_q(en_q), .pend_q(pend_q), .svc_q(svc_q));

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
  localparam int NSRC = 8;
  localparam logic [31:0] A_PEND = 32'hE000_1000, A_EN = 32'hE000_2000,
                          A_CTRL = 32'hE000_2004, A_CLAIM = 32'hE000_2008;

  logic clk = 0, rst_n = 0, we = 0, re = 0, done = 0;
  logic [NSRC-1:0] irq = '0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic ext_irq;
  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_hub #(.NSRC(NSRC), .PRIO_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq), .bus_addr(addr),
    .bus_wdata(wdata), .bus_we(we), .bus_re(re), .bus_rdata(rdata),
    .ext_irq(ext_irq));

  function automatic logic [31:0] prio_a(int id);
    return 32'hE000_0000 + 32'(4 * id);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0; addr = '0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1; #1 d = rdata;
    @(negedge clk); re = 0; addr = '0;
  endtask

  task automatic set_line(int id, logic v);
    @(negedge clk); irq[id-1] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 ext_irq", 32'(ext_irq), 0);
    rd(A_PEND, d);   check("R1 pending", d, 0);
    rd(A_EN, d);     check("R1 enable", d, 0);
    rd(A_CTRL, d);   check("R1 ctrl", d, 0);
    rd(prio_a(3), d); check("R1 priority", d, 0);
    rd(A_CLAIM, d);  check("R1 claim", d, 0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    set_line(2, 1);
    rd(A_PEND, d); check("R2 pend after edge", d, 32'h4);
    check("R3 masked no irq", 32'(ext_irq), 0);
    rd(A_CLAIM, d); check("R3 masked not claimed", d, 0);
    repeat (3) @(negedge clk);
    rd(A_PEND, d); check("R2 held line pends once", d, 32'h4);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(prio_a(2), 32'hFFFF_FFF5);
    rd(prio_a(2), d); check("R4 prio readback", d, 5);
    check("R3 still masked", 32'(ext_irq), 0);
    wr(A_EN, 32'h4);
    check("R9 irq after enable", 32'(ext_irq), 1);
    rd(A_CLAIM, d); check("R7 claim id", d, 2);
    check("R9 irq low after claim", 32'(ext_irq), 0);
    rd(A_PEND, d); check("R7 pending cleared", d, 0);
  endtask

  task automatic t_service;
    logic [31:0] d;
    set_line(2, 0);
    set_line(2, 1);
    rd(A_PEND, d); check("R8 edge dropped in service", d, 0);
    wr(A_CLAIM, 2);
    rd(A_PEND, d); check("R8 no pend from old edge", d, 0);
    set_line(2, 0);
    set_line(2, 1);
    rd(A_PEND, d); check("R8 re-pend after complete", d, 32'h4);
    rd(A_CLAIM, d); check("R8 claim again", d, 2);
    wr(A_CLAIM, 2);
    set_line(2, 0);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr(A_EN, 32'h1FE);
    wr(prio_a(1), 2); wr(prio_a(3), 6); wr(prio_a(5), 6); wr(prio_a(7), 0);
    @(negedge clk); irq = 8'b0101_0101;
    @(negedge clk); irq = '0;
    rd(A_PEND, d); check("R2 four pending", d, 32'hAA);
    rd(A_CLAIM, d); check("R5 tie lowest id", d, 3);
    rd(A_CLAIM, d); check("R5 second of tie", d, 5);
    rd(A_CLAIM, d); check("R5 lower priority last", d, 1);
    rd(A_CLAIM, d); check("R4 zero priority never", d, 0);
    check("R4 no irq for prio 0", 32'(ext_irq), 0);
    rd(A_PEND, d); check("R4 prio0 stays pending", d, 32'h80);
    wr(A_CLAIM, 3); wr(A_CLAIM, 5); wr(A_CLAIM, 1);
  endtask

  task automatic t_lowprio;
    logic [31:0] d;
    wr(prio_a(7), 1);
    check("R9 irq after prio write", 32'(ext_irq), 1);
    wr(A_CTRL, 32'h8000_0002);
    check("R6 suppressed below floor", 32'(ext_irq), 0);
    rd(A_CLAIM, d); check("R6 no claim below floor", d, 0);
    wr(A_CTRL, 32'h0000_0002);
    check("R6 floor ignored when off", 32'(ext_irq), 1);
    wr(A_CTRL, 32'h8000_0001);
    check("R6 equal to floor passes", 32'(ext_irq), 1);
    rd(A_CTRL, d); check("R6 ctrl readback", d, 32'h8000_0001);
    rd(A_CLAIM, d); check("R6 claim id", d, 7);
    wr(A_CLAIM, 7);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(32'hE100_2000, 32'h0);
    rd(A_EN, d); check("R10 out-of-window write ignored", d, 32'h1FE);
    wr(32'hE000_3000, 32'hFFFF_FFFF);
    rd(A_EN, d); check("R10 unmapped write ignored", d, 32'h1FE);
    rd(32'hE100_2000, d); check("R10 out-of-window read", d, 0);
    rd(32'hE000_3000, d); check("R10 unmapped read", d, 0);
    rd(prio_a(3), d); check("R4 prio 3 kept", d, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_edge; t_enable; t_service; t_prio; t_lowprio; t_decode;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule